// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Detect

This block supervises the speed of a motor from its tachometer pulse train. It counts the cycles of a fast reference clock between successive rising edges of the tachometer signal. It then compares that period with a nominal count chosen by two static select pins. A longer period means a slower motor and a shorter one a faster motor. Two active-low flags come out of the comparison: an over-speed flag and an in-lock flag. The lock window is one sixteenth of the nominal count on either side of it.

Alongside the period check, the block halves both the command clock and the tachometer signal and runs a phase-frequency comparison between the two halved waveforms. The resulting pump-up and pump-down pulses feed an external integrator that closes the speed loop. Both pulse inputs are asynchronous and pass through two-flop synchronizers. The select pins are treated as static straps. All interfaces are plain level signals, so there is no flow control and no back-pressure.

Top module: `speed_disc_lock`

## Requirements
- R1: The nominal count N is set by the pins {cnt_sel_a, cnt_sel_b}: 2'b11 gives 128, 2'b01 gives 256, 2'b10 gives 512 and 2'b00 gives 1024. A pin left high reads as 1.
- R2: The measured period is the number of reference clocks between two successive synchronized rising edges of tach_in. The flags change only on such an edge or on saturation (R5).
- R3: On each measurement, overspeed_n goes to 0 if the period is less than N, and goes to 1 otherwise.
- R4: On each measurement, inlock_n goes to 0 if N - N/16 <= period <= N + N/16, with both bounds inclusive, and goes to 1 otherwise.
- R5: The period counter stops at 2N. If it reaches 2N without a tachometer edge, both overspeed_n and inlock_n return to 1.
- R6: The first tachometer rising edge after reset only starts the measurement and leaves both flags at 1.
- R7: pump_up is set by a rising edge of the halved command clock and pump_dn by a rising edge of the halved tachometer signal. Whichever is set is cleared by the other edge. If both edges arrive in the same cycle, both outputs stay 0. The two outputs are never 1 together.
- R8: During reset, overspeed_n = 1, inlock_n = 1, pump_up = 0 and pump_dn = 0.
- R9: tach_in and cmd_clk each pass through a two-flop synchronizer before any edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that the period is counted in |
| rst_n | input | 1 | Asynchronous active-low reset (power-up reset) |
| tach_in | input | 1 | Tachometer pulse train, asynchronous |
| cmd_clk | input | 1 | Speed command clock, asynchronous |
| cnt_sel_a | input | 1 | Nominal count select, first pin |
| cnt_sel_b | input | 1 | Nominal count select, second pin |
| overspeed_n | output | 1 | Low when the last period was shorter than nominal |
| inlock_n | output | 1 | Low when the last period was inside the lock window |
| pump_up | output | 1 | Halved command clock leads the halved tachometer signal |
| pump_dn | output | 1 | Halved command clock lags the halved tachometer signal |

## Verification
The assertions check four things on every cycle: the pump outputs are never high together, the flags hold between tachometer edges, saturation releases both flags, and the decoded nominal count is a single power of two. Other behaviours can only be shown by the bench's scenarios. These are the exact inclusive window bounds at 120/136 and 119/137 for N = 128, the non-monotonic select mapping, the arming edge after reset, and the lead or lag direction of the pump outputs for fast and slow command clocks. The bench's behavioural model tracks every flag and pump output cycle by cycle through all of these scenarios.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Left-shift applied to the base count for each strap setting (R1).
  function automatic logic [1:0] count_shift(input logic sel_a, input logic sel_b);
    logic [1:0] sh;
    case ({sel_a, sel_b})
      2'b11:   sh = 2'd0;
      2'b01:   sh = 2'd1;
      2'b10:   sh = 2'd2;
      default: sh = 2'd3;
    endcase
    return sh;
  endfunction
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // R9: two flops per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= 2'b00;
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end
endmodule

// File: rtl/spd_period_meter.sv
module spd_period_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  input  logic [CNT_W-1:0] nominal,
  output logic             overspeed_n,
  output logic             inlock_n,
  output logic             sat_hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sat_lim, win, lo_lim, hi_lim;
  logic             armed;

  assign sat_lim = nominal << 1;
  assign win     = nominal >> 4;
  assign lo_lim  = nominal - win;
  assign hi_lim  = nominal + win;
  assign sat_hit = (cnt >= sat_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      armed       <= 1'b0;
      overspeed_n <= 1'b1;
      inlock_n    <= 1'b1;
    end else if (edge_in) begin
      cnt   <= CNT_W'(1);
      armed <= 1'b1;
      if (armed) begin                       // R6: first edge only arms
        overspeed_n <= !(cnt < nominal);     // R3
        inlock_n    <= !((cnt >= lo_lim) && (cnt <= hi_lim));  // R4
      end
    end else if (sat_hit) begin              // R5: stalled motor
      overspeed_n <= 1'b1;
      inlock_n    <= 1'b1;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spd_phase_cmp.sv
module spd_phase_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up,
  output logic dn
);
  logic ref_half, fb_half;
  logic ref_edge, fb_edge;
  logic up_nx, dn_nx;

  // A rising edge of the halved signal is a rising input edge while the half is 0.
  assign ref_edge = ref_rise & ~ref_half;
  assign fb_edge  = fb_rise  & ~fb_half;

  always_comb begin
    up_nx = up | ref_edge;
    dn_nx = dn | fb_edge;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_half <= 1'b0;
      fb_half  <= 1'b0;
      up       <= 1'b0;
      dn       <= 1'b0;
    end else begin
      ref_half <= ref_half ^ ref_rise;
      fb_half  <= fb_half ^ fb_rise;
      up       <= up_nx;
      dn       <= dn_nx;
    end
  end
endmodule

// File: rtl/speed_disc_lock.sv
module speed_disc_lock #(
  parameter int BASE_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  input  logic cmd_clk,
  input  logic cnt_sel_a,
  input  logic cnt_sel_b,
  output logic overspeed_n,
  output logic inlock_n,
  output logic pump_up,
  output logic pump_dn
);
  localparam int CNT_W = $clog2(BASE_COUNT) + 5;

  logic [1:0]       sync_q, sync_d, rise;
  logic             tach_rise, cmd_rise, sat_hit;
  logic [CNT_W-1:0] nominal;

  spd_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cmd_clk, tach_in}), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_d <= 2'b00;
    else        sync_d <= sync_q;
  end

  assign rise      = sync_q & ~sync_d;
  assign tach_rise = rise[0];
  assign cmd_rise  = rise[1];
  assign nominal   = CNT_W'(BASE_COUNT) << spd_pkg::count_shift(cnt_sel_a, cnt_sel_b);

  spd_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_in(tach_rise), .nominal(nominal),
    .overspeed_n(overspeed_n), .inlock_n(inlock_n), .sat_hit(sat_hit)
  );

  spd_phase_cmp u_phase (
    .clk(clk), .rst_n(rst_n), .ref_rise(cmd_rise), .fb_rise(tach_rise),
    .up(pump_up), .dn(pump_dn)
  );
endmodule

// File: rtl/speed_disc_lock_chk.sv
module speed_disc_lock_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tach_rise,
  input logic             sat_hit,
  input logic [CNT_W-1:0] nominal,
  input logic             overspeed_n,
  input logic             inlock_n,
  input logic             pump_up,
  input logic             pump_dn
);
  a_r7_pumps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tach_rise && !sat_hit) |=> $stable({overspeed_n, inlock_n}));

  a_r5_sat_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !tach_rise) |=> (overspeed_n && inlock_n));

  a_r1_nominal_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(nominal));
endmodule

bind speed_disc_lock speed_disc_lock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tach_rise(tach_rise), .sat_hit(sat_hit),
  .nominal(nominal), .overspeed_n(overspeed_n), .inlock_n(inlock_n),
  .pump_up(pump_up), .pump_dn(pump_dn)
);

// File: tb/speed_disc_lock_bench.sv
module speed_disc_lock_bench;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tach_in = 1'b0, cmd_clk = 1'b0;
  logic sel_a = 1'b1, sel_b = 1'b1;
  logic overspeed_n, inlock_n, pump_up, pump_dn;

  int tests = 0, fails = 0;
  int up_cyc = 0, dn_cyc = 0;
  int cmd_hp = 0;
  bit mirror = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  speed_disc_lock u_speed_disc_lock (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .cmd_clk(cmd_clk),
    .cnt_sel_a(sel_a), .cnt_sel_b(sel_b),
    .overspeed_n(overspeed_n), .inlock_n(inlock_n),
    .pump_up(pump_up), .pump_dn(pump_dn)
  );

  // Behavioural reference model, advanced at each rising clock edge.
  int m_t1, m_t2, m_t3, m_c1, m_c2, m_c3;
  int m_cnt, m_nom;
  bit m_armed, m_ovs, m_lock, m_ch, m_th, m_up, m_dn;
  bit t_rise, c_rise, ce, te, nu, nd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t1 = 0; m_t2 = 0; m_t3 = 0; m_c1 = 0; m_c2 = 0; m_c3 = 0;
      m_cnt = 0; m_armed = 0; m_ovs = 1; m_lock = 1;
      m_ch = 0; m_th = 0; m_up = 0; m_dn = 0;
    end else begin
      t_rise = (m_t2 == 1) && (m_t3 == 0);
      c_rise = (m_c2 == 1) && (m_c3 == 0);
      m_t3 = m_t2; m_t2 = m_t1; m_t1 = int'(tach_in);
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = int'(cmd_clk);
      case ({sel_a, sel_b})
        2'b11: m_nom = 128;
        2'b01: m_nom = 256;
        2'b10: m_nom = 512;
        default: m_nom = 1024;
      endcase
      if (t_rise) begin
        if (m_armed) begin
          m_ovs  = !(m_cnt < m_nom);
          m_lock = !(m_cnt >= m_nom - m_nom/16 && m_cnt <= m_nom + m_nom/16);
        end
        m_armed = 1; m_cnt = 1;
      end else if (m_cnt >= 2*m_nom) begin
        m_ovs = 1; m_lock = 1;
      end else begin
        m_cnt++;
      end
      ce = c_rise && !m_ch;
      te = t_rise && !m_th;
      if (c_rise) m_ch = !m_ch;
      if (t_rise) m_th = !m_th;
      nu = m_up || ce; nd = m_dn || te;
      if (nu && nd) begin nu = 0; nd = 0; end
      m_up = nu; m_dn = nd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(overspeed_n == m_ovs, "R3 overspeed_n vs model", int'(overspeed_n), int'(m_ovs));
      chk(inlock_n == m_lock, "R4 inlock_n vs model", int'(inlock_n), int'(m_lock));
      chk(pump_up == m_up, "R7 pump_up vs model", int'(pump_up), int'(m_up));
      chk(pump_dn == m_dn, "R7 pump_dn vs model", int'(pump_dn), int'(m_dn));
      if (pump_up) up_cyc++;
      if (pump_dn) dn_cyc++;
    end
  end

  // Command clock generator: toggles every cmd_hp cycles when enabled.
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (cmd_hp != 0) begin
        k++;
        if (k >= cmd_hp) begin cmd_clk = ~cmd_clk; k = 0; end
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int per, input int n);
    for (int p = 0; p < n; p++) begin
      tach_in = 1'b1; if (mirror) cmd_clk = 1'b1;
      cycles(per / 2);
      tach_in = 1'b0; if (mirror) cmd_clk = 1'b0;
      cycles(per - per / 2);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    cycles(4);
    chk(overspeed_n && inlock_n && !pump_up && !pump_dn, "R8 reset outputs",
        int'({overspeed_n, inlock_n, pump_up, pump_dn}), 4'b1100);
    rst_n = 1'b1;
  endtask

  task automatic flags(input bit e_ovs, input bit e_lock, input string tag);
    chk(overspeed_n == e_ovs, {tag, " overspeed_n"}, int'(overspeed_n), int'(e_ovs));
    chk(inlock_n == e_lock, {tag, " inlock_n"}, int'(inlock_n), int'(e_lock));
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 R9: N = 128, command mirrors tachometer, so halved edges coincide
    sel_a = 1; sel_b = 1; mirror = 1;
    up_cyc = 0; dn_cyc = 0;
    pulses(128, 6);
    flags(1, 0, "R1 R4 N=128 period 128");
    chk(up_cyc == 0 && dn_cyc == 0, "R7 aligned edges no pump", up_cyc + dn_cyc, 0);
    mirror = 0;
    pulses(100, 4);  flags(0, 1, "R3 fast period 100");
    pulses(120, 4);  flags(0, 0, "R4 lower bound 120 inclusive");
    pulses(119, 3);  flags(0, 1, "R4 just below window 119");
    pulses(136, 3);  flags(1, 0, "R4 upper bound 136 inclusive");
    pulses(137, 3);  flags(1, 1, "R4 just above window 137");
    // R6: first edge after reset only arms
    do_reset();
    pulses(128, 1);  flags(1, 1, "R6 arming edge");
    pulses(128, 1);  flags(1, 0, "R6 second edge measures");
    // R1 other straps
    sel_a = 0; sel_b = 1;
    pulses(256, 3);  flags(1, 0, "R1 N=256 period 256");
    sel_a = 1; sel_b = 0;
    pulses(480, 3);  flags(0, 0, "R1 N=512 period 480");
    sel_a = 0; sel_b = 0;
    pulses(1100, 3); flags(1, 1, "R1 N=1024 period 1100");
    pulses(1088, 3); flags(1, 0, "R1 N=1024 period 1088");
    // R5 stall: no edges for more than 2N cycles
    cycles(2200);
    flags(1, 1, "R5 stalled motor");
    // R7 lead and lag with N=128
    sel_a = 1; sel_b = 1;
    do_reset();
    up_cyc = 0; dn_cyc = 0; cmd_hp = 50;
    pulses(128, 12);
    chk(up_cyc > dn_cyc, "R7 fast command pumps up", up_cyc, dn_cyc);
    do_reset();
    up_cyc = 0; dn_cyc = 0; cmd_hp = 80;
    pulses(128, 12);
    chk(dn_cyc > up_cyc, "R7 slow command pumps down", dn_cyc, up_cyc);
    cmd_hp = 0;
    cycles(10);
    summary();
  end
endmodule